// File: doc/BRIEF.md
# Double-Buffered PWM Channel

A single 8-bit pulse-width modulation channel. A free-running up-counter advances on each clock-enable tick and is compared against an active period value and an active duty value. Software writes land in shadow buffers. While the channel runs, the active values are refreshed from the buffers only at safe points: the counter wrap, an explicit counter write, or disabling the channel. Each period on the pin is therefore either entirely the old waveform or entirely the new one.

A polarity bit picks the level the output starts each period with. The duty count is the high time when polarity is 1 and the low time when polarity is 0. A channel that is switched off passes register writes straight to the active values and parks its output at the inactive level.

Top module: `pwm_dbuf_chan`

## Requirements
- R1: After reset the period, duty, control and counter are all 0, the channel is disabled with polarity 0, and `pwm_o` is 1.
- R2: While the channel is enabled, a write to select 1 (duty) or select 0 (period) changes only the buffer. The waveform keeps following the previous active values.
- R3: When the counter wraps from period−1 to 0, the buffered period and duty become the active values.
- R4: A write of any data to select 3 sets the counter to 0 and copies both buffers into the active values on the same edge.
- R5: A write to select 2 that clears bit 0 (enable) while the channel is running copies both buffers into the active values. While the channel is disabled, the counter holds at 0 and `pwm_o` equals the inverse of polarity.
- R6: While the channel is disabled, a period or duty write updates the buffer and the active value together.
- R7: While enabled with a nonzero active period, the counter advances by one only on a cycle with `tick_i` high. After period−1 it returns to 0. It holds on cycles without a tick.
- R8: With polarity (select 2, bit 1) = 1, `pwm_o` is 1 while counter < active duty and 0 otherwise.
- R9: With polarity = 0, `pwm_o` is 0 while counter < active duty and 1 otherwise.
- R10: An active duty ≥ active period keeps the first level for the whole period. An active duty of 0 keeps the second level for the whole period.
- R11: With an enabled channel and active period 0, the counter stays at 0 and `pwm_o` equals polarity.
- R12: `rd_data_o` is combinational on `rd_sel_i`: select 0 gives the period buffer, select 1 the duty buffer, select 2 {6'b0, polarity, enable}, and select 3 the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Counter clock enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write select: 0 period, 1 duty, 2 control, 3 counter |
| wr_data_i | input | 8 | Write data |
| rd_sel_i | input | 2 | Read select, same encoding |
| rd_data_o | output | 8 | Read data |
| pwm_o | output | 1 | PWM output |

## Verification
The assertions assume one write per cycle on a single select. They also assume `wr_sel_i` and `wr_data_i` are stable whenever `wr_en_i` is high at a clock edge. The counter-range property relies on the active period changing only while the counter is 0 or the channel is off. That holds only if writes respect the buffering rules. The stimulus drives every input one time unit after the rising edge and issues at most one write per cycle. It mixes directed sequences, such as a duty change in mid-period, a disable in mid-period, period 0, and duty at or above the period, with a long run of random writes and ticks.

// File: rtl/pwm_dbuf_pkg.sv
package pwm_dbuf_pkg;
  typedef enum logic [1:0] {
    SEL_PER  = 2'd0,
    SEL_DUTY = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_CNT  = 2'd3
  } sel_e;

  localparam int unsigned CTRL_EN_BIT  = 0;
  localparam int unsigned CTRL_POL_BIT = 1;
  localparam int unsigned NUM_SHADOW   = 2;  // period, duty
  localparam int unsigned SH_PER       = 0;
  localparam int unsigned SH_DUTY      = 1;
endpackage

// File: rtl/pwm_dbuf_regs.sv
module pwm_dbuf_regs
  import pwm_dbuf_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_sel_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          wrap_i,
  output logic [DW-1:0] per_buf_o,
  output logic [DW-1:0] duty_buf_o,
  output logic [DW-1:0] per_act_o,
  output logic [DW-1:0] duty_act_o,
  output logic          en_o,
  output logic          pol_o,
  output logic          cnt_clr_o
);
  logic [NUM_SHADOW-1:0][DW-1:0] buf_q, act_q;
  logic en_q, pol_q;
  logic sel_ctrl, sel_cnt, disabling, load;

  assign sel_ctrl  = wr_en_i && (wr_sel_i == SEL_CTRL);
  assign sel_cnt   = wr_en_i && (wr_sel_i == SEL_CNT);
  assign disabling = sel_ctrl && en_q && !wr_data_i[CTRL_EN_BIT];
  assign cnt_clr_o = sel_cnt || disabling;
  assign load      = wrap_i || cnt_clr_o;

  for (genvar g = 0; g < NUM_SHADOW; g++) begin : g_shadow
    localparam logic [1:0] MY_SEL = (g == SH_PER) ? SEL_PER : SEL_DUTY;
    logic hit;
    assign hit = wr_en_i && (wr_sel_i == MY_SEL);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        buf_q[g] <= '0;
        act_q[g] <= '0;
      end else begin
        if (hit) buf_q[g] <= wr_data_i;
        // load takes the buffer as it stood before this edge
        if (load)             act_q[g] <= buf_q[g];
        else if (hit && !en_q) act_q[g] <= wr_data_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      pol_q <= 1'b0;
    end else if (sel_ctrl) begin
      en_q  <= wr_data_i[CTRL_EN_BIT];
      pol_q <= wr_data_i[CTRL_POL_BIT];
    end
  end

  assign per_buf_o  = buf_q[SH_PER];
  assign duty_buf_o = buf_q[SH_DUTY];
  assign per_act_o  = act_q[SH_PER];
  assign duty_act_o = act_q[SH_DUTY];
  assign en_o       = en_q;
  assign pol_o      = pol_q;
endmodule

// File: rtl/pwm_dbuf_cnt.sv
module pwm_dbuf_cnt #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          clr_i,
  input  logic          tick_i,
  input  logic [DW-1:0] per_i,
  output logic [DW-1:0] cnt_o,
  output logic          wrap_o
);
  logic [DW-1:0] cnt_q;
  logic at_last, per_zero;

  assign per_zero = (per_i == '0);
  assign at_last  = (cnt_q == per_i - 1'b1);
  assign wrap_o   = en_i && !clr_i && tick_i && !per_zero && at_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!en_i || clr_i)     cnt_q <= '0;
    else if (tick_i) begin
      if (per_zero || at_last)   cnt_q <= '0;
      else                       cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pwm_dbuf_out.sv
module pwm_dbuf_out #(
  parameter int unsigned DW = 8
) (
  input  logic          en_i,
  input  logic          pol_i,
  input  logic [DW-1:0] cnt_i,
  input  logic [DW-1:0] per_i,
  input  logic [DW-1:0] duty_i,
  output logic          pwm_o
);
  logic first_phase;

  // duty >= period leaves counter below duty for the whole period
  assign first_phase = (per_i == '0) || (cnt_i < duty_i);

  always_comb begin
    if (!en_i)            pwm_o = ~pol_i;
    else if (first_phase) pwm_o = pol_i;
    else                  pwm_o = ~pol_i;
  end
endmodule

// File: rtl/pwm_dbuf_chan.sv
module pwm_dbuf_chan
  import pwm_dbuf_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_sel_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [1:0]    rd_sel_i,
  output logic [DW-1:0] rd_data_o,
  output logic          pwm_o
);
  logic [DW-1:0] per_buf, duty_buf, per_act, duty_act, cnt;
  logic en, pol, cnt_clr, wrap;

  pwm_dbuf_regs #(.DW(DW)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i,
    .wrap_i    (wrap),
    .per_buf_o (per_buf),
    .duty_buf_o(duty_buf),
    .per_act_o (per_act),
    .duty_act_o(duty_act),
    .en_o      (en),
    .pol_o     (pol),
    .cnt_clr_o (cnt_clr)
  );

  pwm_dbuf_cnt #(.DW(DW)) u_cnt (
    .clk_i, .rst_ni,
    .en_i  (en),
    .clr_i (cnt_clr),
    .tick_i,
    .per_i (per_act),
    .cnt_o (cnt),
    .wrap_o(wrap)
  );

  pwm_dbuf_out #(.DW(DW)) u_out (
    .en_i  (en),
    .pol_i (pol),
    .cnt_i (cnt),
    .per_i (per_act),
    .duty_i(duty_act),
    .pwm_o
  );

  always_comb begin
    rd_data_o = '0;
    unique case (sel_e'(rd_sel_i))
      SEL_PER:  rd_data_o = per_buf;
      SEL_DUTY: rd_data_o = duty_buf;
      SEL_CTRL: begin
        rd_data_o[CTRL_EN_BIT]  = en;
        rd_data_o[CTRL_POL_BIT] = pol;
      end
      SEL_CNT:  rd_data_o = cnt;
      default:  rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/pwm_dbuf_chk.sv
module pwm_dbuf_chk
  import pwm_dbuf_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tick_i,
  input logic          wr_en_i,
  input logic [1:0]    wr_sel_i,
  input logic [DW-1:0] wr_data_i,
  input logic          pwm_o,
  input logic [DW-1:0] cnt,
  input logic [DW-1:0] per_act,
  input logic [DW-1:0] duty_act,
  input logic [DW-1:0] duty_buf,
  input logic          en,
  input logic          pol
);
  AST_ACT_CHANGE_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && $past(en) && duty_act != $past(duty_act)) |-> cnt == '0); // R3

  AST_CNT_WR_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == SEL_CNT) |=> cnt == '0); // R4

  AST_DIS_PARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |-> (cnt == '0 && pwm_o == !pol)); // R5

  AST_DIS_WRITE_THRU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en && wr_en_i && wr_sel_i == SEL_DUTY) |=> duty_act == $past(wr_data_i)); // R6

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && per_act != '0) |-> cnt < per_act); // R7

  AST_NO_TICK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && !tick_i && !wr_en_i) |=> $stable(cnt)); // R7

  AST_PER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && per_act == '0) |-> (cnt == '0 && pwm_o == pol)); // R11

  AST_BUF_TAKES_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == SEL_DUTY) |=> duty_buf == $past(wr_data_i)); // R12
endmodule

bind pwm_dbuf_chan pwm_dbuf_chk #(.DW(DW)) u_chk (
  .clk_i, .rst_ni, .tick_i, .wr_en_i, .wr_sel_i, .wr_data_i, .pwm_o,
  .cnt(cnt), .per_act(per_act), .duty_act(duty_act), .duty_buf(duty_buf),
  .en(en), .pol(pol)
);

// File: tb/sim_pwm_dbuf_chan.sv
`timescale 1ns/1ps
module sim_pwm_dbuf_chan;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [1:0] rd_sel = 2'd0;
  logic [7:0] rd_data;
  logic       pwm;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pwm_dbuf_chan u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .wr_sel_i(wr_sel), .wr_data_i(wr_data), .rd_sel_i(rd_sel),
    .rd_data_o(rd_data), .pwm_o(pwm)
  );

  // behavioural reference
  int m_pbuf, m_dbuf, m_pact, m_dact, m_cnt;
  bit m_en, m_pol;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pbuf = 0; m_dbuf = 0; m_pact = 0; m_dact = 0; m_cnt = 0;
      m_en = 0; m_pol = 0;
    end else begin
      int pb, db, pa, da, c;
      bit e, p, ld, clr;
      pb = m_pbuf; db = m_dbuf; pa = m_pact; da = m_dact; c = m_cnt;
      e = m_en; p = m_pol; ld = 0; clr = 0;
      if (wr_en) begin
        case (wr_sel)
          2'd0: begin pb = wr_data; if (!m_en) pa = wr_data; end
          2'd1: begin db = wr_data; if (!m_en) da = wr_data; end
          2'd2: begin
            e = wr_data[0]; p = wr_data[1];
            if (m_en && !wr_data[0]) begin ld = 1; clr = 1; end
          end
          default: begin ld = 1; clr = 1; end
        endcase
      end
      if (!m_en || clr) c = 0;
      else if (tick) begin
        if (m_pact == 0) c = 0;
        else if (m_cnt == m_pact - 1) begin c = 0; ld = 1; end
        else c = m_cnt + 1;
      end
      if (ld) begin pa = m_pbuf; da = m_dbuf; end
      m_pbuf = pb; m_dbuf = db; m_pact = pa; m_dact = da; m_cnt = c;
      m_en = e; m_pol = p;
    end
  end

  function automatic bit exp_pwm();
    if (!m_en) return !m_pol;
    if (m_pact == 0) return m_pol;
    return (m_cnt < m_dact) ? m_pol : !m_pol;
  endfunction

  function automatic int exp_rd(input logic [1:0] s);
    case (s)
      2'd0: return m_pbuf;
      2'd1: return m_dbuf;
      2'd2: return {m_pol, m_en};
      default: return m_cnt;
    endcase
  endfunction

  function automatic string pwm_tag();
    if (!m_en) return "R5";
    if (m_pact == 0) return "R11";
    if (m_dact == 0 || m_dact >= m_pact) return "R10";
    return m_pol ? "R8" : "R9";
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      cycles++;
      check(pwm_tag(), pwm, exp_pwm());
      check((rd_sel == 2'd3) ? "R7" : "R12", rd_data, exp_rd(rd_sel));
      if (cycles > 150000) begin
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  task automatic cyc(input bit t, input bit we = 0, input logic [1:0] s = 0,
                     input logic [7:0] d = 0);
    @(posedge clk); #1;
    tick = t; wr_en = we; wr_sel = s; wr_data = d;
    rd_sel = rd_sel + 2'd1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1);
  endtask

  task automatic probe(input string tag, input logic [1:0] s);
    @(posedge clk); #1;
    tick = 0; wr_en = 0; rd_sel = s;
    @(negedge clk);
    check(tag, rd_data, exp_rd(s));
    check(tag, pwm, exp_pwm());
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", pwm, 1);
    check("R1", rd_data, 0);
    #1 rst_n = 1;
    probe("R1", 2'd2);

    cyc(0, 1, 2'd0, 8'd10);                 // disabled: write-through
    cyc(0, 1, 2'd1, 8'd3);
    probe("R6", 2'd1);
    cyc(0, 1, 2'd2, 8'b11);                 // enable, pol 1
    idle(25);
    probe("R8", 2'd3);
    idle(4);
    cyc(1, 1, 2'd1, 8'd7);                  // mid-period duty change
    probe("R2", 2'd1);
    idle(3);
    probe("R2", 2'd3);
    idle(12);
    probe("R3", 2'd3);
    for (int i = 0; i < 30; i++) cyc(i % 3 == 0);   // sparse ticks
    probe("R7", 2'd3);
    cyc(1, 1, 2'd0, 8'd6);
    cyc(1, 1, 2'd3, 8'd55);                 // counter write loads
    probe("R4", 2'd3);
    idle(10);
    cyc(1, 1, 2'd2, 8'b01);                 // pol 0
    idle(20);
    probe("R9", 2'd2);
    cyc(1, 1, 2'd1, 8'd9);                  // duty above period
    idle(20);
    probe("R10", 2'd1);
    cyc(1, 1, 2'd1, 8'd0);
    idle(20);
    probe("R10", 2'd3);
    cyc(1, 1, 2'd0, 8'd0);                  // period 0
    idle(20);
    probe("R11", 2'd3);
    cyc(1, 1, 2'd3, 8'd0);
    idle(5);
    probe("R11", 2'd0);
    cyc(1, 1, 2'd0, 8'd8);
    cyc(1, 1, 2'd3, 8'd0);
    cyc(1, 1, 2'd2, 8'b11);
    idle(3);
    cyc(1, 1, 2'd1, 8'd2);
    cyc(1, 1, 2'd2, 8'b10);                 // disable mid-period
    probe("R5", 2'd3);
    idle(5);
    probe("R5", 2'd2);

    for (int i = 0; i < 20000; i++) begin
      int r;
      r = $urandom % 32;
      if (r == 0)       cyc($urandom % 4 != 0, 1, 2'd0, 8'($urandom % 20));
      else if (r == 1)  cyc($urandom % 4 != 0, 1, 2'd1, 8'($urandom % 24));
      else if (r == 2)  cyc($urandom % 4 != 0, 1, 2'd2, 8'($urandom % 4 == 0 ? 0 : {$urandom % 2, 1'b1}));
      else if (r == 3)  cyc($urandom % 4 != 0, 1, 2'd3, 8'($urandom));
      else              cyc($urandom % 4 != 0);
    end
    probe("R12", 2'd0);

    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule